// File: doc/BRIEF.md
# LFSR-Timed Program Counter Sampler

This block records a monitored program-counter value into an on-chip trace buffer at a fixed cycle interval. The interval comes from a 24-bit shift register with linear feedback. Software loads it with any nonzero start state, and the register then steps once per clock toward one fixed terminal state. Each time the terminal state is reached, the present program counter is pushed into a 256-entry buffer and the register reloads the start state without software help. The register counts clock cycles, not time, so a change of clock frequency leaves the interval in cycles unchanged.

Software reads the buffer through a strobe-driven read port and gets the oldest sample first. Status outputs report the number of stored samples, a half-full level, an empty flag, a sticky overflow flag and a saturating count of dropped samples. Software uses these to confirm that it drains the buffer often enough. A start state that lies d steps before the terminal state gives one capture every d+1 enabled cycles.

Top module: `pc_sampler`

## Requirements
- R1: After reset `fill_level` is 0, `empty` is 1, `half_full`, `overflow` and `rd_underflow` are 0, and `drop_count` and `rd_data` are 0. The stored start state is the terminal state 24'h000001.
- R2: On each cycle where `enable` is high and was high on the previous cycle, the state s advances to {s[22:0], s[23]^s[22]^s[21]^s[16]}. A capture happens on such a cycle exactly when s equals 24'h000001.
- R3: In the cycle that captures, the state reloads the stored start state instead of stepping. A start state d steps before 24'h000001 therefore yields captures d+1 cycles apart.
- R4: A `start_wr` pulse stores `start_val`, with 0 replaced by 24'h000001. The new value takes effect only at the next reload and does not disturb the running state.
- R5: A capture stores the `pc_in` value present on the capture cycle as one buffer entry. The buffer holds 256 entries.
- R6: `fill_level` equals the number of stored entries, and `empty` is 1 exactly when that number is 0. Both update one clock after the push or pop.
- R7: A `rd_stb` cycle on a non-empty buffer removes the oldest entry and presents it on `rd_data` on the next cycle. `rd_data` holds its value when no read occurs.
- R8: A `rd_stb` cycle on an empty buffer sets `rd_data` to 0 and raises `rd_underflow` for one cycle, and it removes nothing. Emptiness is judged before any push in that same cycle.
- R9: `half_full` is 1 exactly when at least 128 entries are stored.
- R10: A capture while 256 entries are stored, judged before any pop in the same cycle, is dropped. A drop sets the sticky `overflow` and increments `drop_count`, which saturates at 255.
- R11: `clr_ovf` clears `overflow` and `drop_count` on the next edge. It takes priority over a drop in the same cycle.
- R12: While `enable` is low, the state holds and no capture occurs. The first cycle with `enable` high after it was low loads the stored start state and captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sampling enable |
| start_wr | input | 1 | Store `start_val` as the start state |
| start_val | input | 24 | Start state to store |
| pc_in | input | 32 | Monitored program counter |
| rd_stb | input | 1 | Pop one buffer entry |
| rd_data | output | 32 | Entry popped by the last read |
| rd_underflow | output | 1 | Last read found the buffer empty |
| clr_ovf | input | 1 | Clear overflow flag and drop count |
| fill_level | output | 9 | Stored entry count |
| half_full | output | 1 | At least 128 entries stored |
| empty | output | 1 | No entries stored |
| overflow | output | 1 | Sticky: a sample was dropped |
| drop_count | output | 8 | Saturating dropped-sample count |

## Verification
A wrong shift-register state or missed reload does not show at once. It first appears as a `fill_level` step one or more cycles away from the expected capture cycle. A wrong pointer shows only when that entry is read back through `rd_data`, one cycle after the strobe. The bench compares every output against a behavioural model on every clock, so a timing slip appears within one sample interval and a data slip appears at the first read of the affected entry. Full-buffer drops, saturation and the clear priority are driven long enough for `drop_count` to pass 255.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int LFSR_W = 24;
  localparam logic [LFSR_W-1:0] TERM_STATE = 24'h000001;

  // one Fibonacci step, feedback from stages 24, 23, 22 and 17
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[23] ^ s[22] ^ s[21] ^ s[16]};
  endfunction

  function automatic logic [LFSR_W-1:0] fix_start(input logic [LFSR_W-1:0] v);
    return (v == '0) ? TERM_STATE : v;
  endfunction
endpackage

// File: rtl/pcs_interval.sv
module pcs_interval
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start_wr,
  input  logic [LFSR_W-1:0] start_val,
  output logic              hit
);
  logic [LFSR_W-1:0] state_q, start_q;
  logic              en_q;
  logic              running;

  assign running = enable & en_q;
  assign hit     = running && (state_q == TERM_STATE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TERM_STATE;
      start_q <= TERM_STATE;
      en_q    <= 1'b0;
    end else begin
      en_q <= enable;
      if (start_wr) start_q <= fix_start(start_val);
      if (enable) begin
        if (!en_q || state_q == TERM_STATE) state_q <= start_q;
        else                                 state_q <= lfsr_step(state_q);
      end
    end
  end

  // R3: a capture reloads the start state held before the edge
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> state_q == $past(start_q));
  // R2: the all-zero state is never entered
  a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R12: disabled sampling freezes the state
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(state_q));
  // R12: the first enabled cycle captures nothing
  a_r12_no_first_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> !hit);
endmodule

// File: rtl/pcs_fifo.sv
module pcs_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          underflow,
  output logic [AW:0]   level,
  output logic          dropped
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          is_full, is_empty, push_ok, pop_ok;

  assign is_full  = (level == (AW+1)'(DEPTH));
  assign is_empty = (level == '0);
  assign push_ok  = push & ~is_full;
  assign pop_ok   = pop & ~is_empty;
  assign dropped  = push & is_full;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      level     <= '0;
      rdata     <= '0;
      underflow <= 1'b0;
    end else begin
      underflow <= pop & is_empty;
      if (pop) rdata <= pop_ok ? mem[rptr] : '0;
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R10: occupancy never exceeds the depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));
  // R8: an empty read without a push leaves the occupancy alone
  a_r8_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && is_empty && !push) |=> (level == '0 && underflow));
  // R6: a lone push grows the occupancy by one
  a_r6_push_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop) |=> level == $past(level) + 1'b1);
endmodule

// File: rtl/pc_sampler.sv
module pc_sampler
  import pcs_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DEPTH  = 256,
  parameter int DROP_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start_wr,
  input  logic [LFSR_W-1:0] start_val,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              rd_stb,
  output logic [PC_W-1:0]   rd_data,
  output logic              rd_underflow,
  input  logic              clr_ovf,
  output logic [AW:0]       fill_level,
  output logic              half_full,
  output logic              empty,
  output logic              overflow,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [AW:0] HALF_MARK = (AW+1)'(DEPTH / 2);

  logic sample_hit;
  logic sample_drop;

  pcs_interval u_interval (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .start_wr  (start_wr),
    .start_val (start_val),
    .hit       (sample_hit)
  );

  pcs_fifo #(.W(PC_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (sample_hit),
    .wdata     (pc_in),
    .pop       (rd_stb),
    .rdata     (rd_data),
    .underflow (rd_underflow),
    .level     (fill_level),
    .dropped   (sample_drop)
  );

  assign half_full = (fill_level >= HALF_MARK);
  assign empty     = (fill_level == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_ovf) begin
      overflow   <= 1'b0;
      drop_count <= '0;
    end else if (sample_drop) begin
      overflow <= 1'b1;
      if (drop_count != '1) drop_count <= drop_count + 1'b1;
    end
  end

  // R10: overflow stays set until cleared
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_ovf) |=> overflow);
  // R11: clear wins over everything
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovf |=> (!overflow && drop_count == '0));
  // R10: the drop count never wraps back to zero
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == '1 && !clr_ovf) |=> drop_count == '1);
endmodule

// File: tb/pc_sampler_tb.sv
module pc_sampler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, start_wr = 1'b0, rd_stb = 1'b0, clr_ovf = 1'b0;
  logic [23:0] start_val = '0;
  logic [31:0] pc_in = 32'h1000_0000;
  logic [31:0] rd_data;
  logic        rd_underflow, half_full, empty, overflow;
  logic [8:0]  fill_level;
  logic [7:0]  drop_count;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pc_sampler dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_wr(start_wr),
    .start_val(start_val), .pc_in(pc_in), .rd_stb(rd_stb),
    .rd_data(rd_data), .rd_underflow(rd_underflow), .clr_ovf(clr_ovf),
    .fill_level(fill_level), .half_full(half_full), .empty(empty),
    .overflow(overflow), .drop_count(drop_count)
  );

  // behavioural reference
  int unsigned m_start = 1, m_st = 1;
  bit          m_enq = 0, m_uf = 0, m_ovf = 0;
  int unsigned m_rd = 0, m_drop = 0;
  int unsigned q[$];

  function automatic int unsigned fwd(int unsigned s);
    int unsigned fb = $countones(s & 32'h00E1_0000) % 2;
    return ((s << 1) | fb) & 32'h00FF_FFFF;
  endfunction

  // state d steps before the terminal state, by walking backwards
  function automatic int unsigned before_term(int d);
    int unsigned s = 1;
    for (int i = 0; i < d; i++) begin
      int unsigned top = ((s >> 0) ^ (s >> 23) ^ (s >> 22) ^ (s >> 17)) & 1;
      s = (top << 23) | (s >> 1);
    end
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit cap = enable && m_enq && (m_st == 1);
    int n = q.size();
    if (enable) begin
      if (!m_enq || m_st == 1) m_st = m_start;
      else m_st = fwd(m_st);
    end
    m_enq = enable;
    if (start_wr) m_start = (start_val == 0) ? 1 : start_val;
    m_uf = 0;
    if (rd_stb) begin
      if (n > 0) m_rd = q.pop_front();
      else begin m_rd = 0; m_uf = 1; end
    end
    if (clr_ovf) begin m_ovf = 0; m_drop = 0; end
    else if (cap && n >= 256) begin
      m_ovf = 1;
      if (m_drop < 255) m_drop++;
    end
    if (cap && n < 256) q.push_back(pc_in);
  endtask

  task automatic compare();
    chk("R5/R7 rd_data", rd_data, m_rd);
    chk("R8 rd_underflow", 32'(rd_underflow), 32'(m_uf));
    chk("R2/R3/R6/R12 fill_level", 32'(fill_level), q.size());
    chk("R6 empty", 32'(empty), 32'(q.size() == 0));
    chk("R9 half_full", 32'(half_full), 32'(q.size() >= 128));
    chk("R10/R11 overflow", 32'(overflow), 32'(m_ovf));
    chk("R10/R11 drop_count", 32'(drop_count), m_drop);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    pc_in = pc_in + 32'h4;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic write_start(int unsigned v);
    start_wr = 1'b1; start_val = 24'(v);
    cycle();
    start_wr = 1'b0;
  endtask

  task automatic read_one();
    rd_stb = 1'b1; cycle(); rd_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    compare();
    // R2/R3: start 5 steps before the terminal state, captures every 6 cycles
    write_start(before_term(5));
    enable = 1'b1;
    run(40);
    read_one(); run(2); read_one(); read_one();
    // R4: new start takes effect at the next reload
    write_start(before_term(20));
    run(60);
    read_one();
    // R4: zero load acts as terminal state, a capture every cycle; R10 fill and drop
    write_start(0);
    run(320);
    // R11: clear while drops continue
    clr_ovf = 1'b1; cycle(); clr_ovf = 1'b0;
    run(300);
    // R12: disable holds; R7/R8 drain past empty
    enable = 1'b0;
    run(10);
    rd_stb = 1'b1;
    run(262);
    rd_stb = 1'b0;
    clr_ovf = 1'b1; cycle(); clr_ovf = 1'b0;
    // R12: re-enable reloads the stored start state
    write_start(before_term(7));
    run(3);
    enable = 1'b1;
    run(50);
    // R8: reads on an empty or nearly empty buffer while sampling
    rd_stb = 1'b1;
    run(30);
    rd_stb = 1'b0;
    run(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule